// File: doc/BRIEF.md
# Windowed discrepancy fitness evaluator

This block scores configurations of a triplicated, reconfigurable datapath by watching how closely two of its redundant lanes agree on live traffic. Each candidate configuration is put into service with a one-cycle load strobe. A few samples are then dropped while the pipeline flushes the old configuration's results. After that, the block sums the squared difference of the two signed lane outputs over a fixed window of valid samples. A smaller sum means a fitter candidate. Omitting the square root leaves the ranking unchanged. No stored test vectors or golden outputs are needed.

When a window closes, the score goes into a per-candidate table and the next candidate is loaded. After the last member of the population has been scored, a generation-done pulse marks that the whole table is ready for the selection logic, and the index wraps to zero. A score of zero means a configuration has been found on which the two lanes agree exactly. The block then pulses a solution flag, latches that candidate's index and stops issuing loads until it is reset. Selection and breeding of new candidates happen elsewhere; that logic reads the table through its own registered port.

Top module: `disc_fitness_eval`

## Requirements
- R1: While reset is held and right after its release, cand_idx_o and sol_idx_o are 0, and cfg_load_o, gen_done_o and sol_found_o are 0. Every table entry reads as all-ones (2^ACC_W-1), meaning "not yet scored".
- R2: In the second cycle after reset is released, cfg_load_o is high for exactly one cycle with cand_idx_o = 0.
- R3: A sample presented during a cfg_load_o cycle is discarded. So are the first SKIP_LEN (default 2) valid samples after it. None of them reach the score.
- R4: The score is the sum of (lane_a_i - lane_b_i)^2 over the next WIN_LEN (default 100) cycles with smp_vld_i high. Both lanes are two's-complement DATA_W-bit values. Cycles with smp_vld_i low add nothing and do not advance the window.
- R5: The sum saturates at 2^ACC_W-1 (ACC_W default 24) and never wraps.
- R6: Let the last counted sample be presented in cycle k. A sample in cycle k+1 is ignored. In cycle k+2, cfg_load_o is high and cand_idx_o shows the next candidate.
- R7: When candidate POP_SIZE-1 (default 49) is scored with a nonzero result, gen_done_o pulses in the same cycle as cfg_load_o, and cand_idx_o returns to 0.
- R8: A score of exactly 0 pulses sol_found_o in cycle k+2 and latches that candidate's index into sol_idx_o. No cfg_load_o is issued, cand_idx_o holds its value, and from then on no strobe pulses until reset.
- R9: rd_score_o returns the table entry for rd_idx_i one cycle after the index is presented, and reflects a window's score from cycle k+2. An index of POP_SIZE or above reads all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Lane samples valid this cycle |
| lane_a_i | input | DATA_W | First redundant lane output, signed |
| lane_b_i | input | DATA_W | Second redundant lane output, signed |
| cand_idx_o | output | IDX_W | Candidate currently in service |
| cfg_load_o | output | 1 | One-cycle strobe: apply configuration cand_idx_o |
| gen_done_o | output | 1 | One-cycle pulse: every candidate has a score |
| sol_found_o | output | 1 | One-cycle pulse: a zero-discrepancy candidate was found |
| sol_idx_o | output | IDX_W | Index of the zero-discrepancy candidate |
| rd_idx_i | input | IDX_W | Score table read index |
| rd_score_o | output | ACC_W | Score table read data, one cycle after rd_idx_i |

## Verification
The bench drives inputs and samples outputs at falling edges and counts rising edges from the cycle that holds the last counted sample. In the next cycle the strobes must still be low. Two cycles later the load strobe, the new index, the generation pulse or the solution pulse must appear. The stored score is then read back one cycle after its index is presented. Samples sent during the load cycle, during the skip period and in the cycle between window end and load carry large discrepancies. Any of them leaking into a sum would therefore show up in a score read back later. After a solution, the bench sends another full window of traffic and checks that no further strobe appears.

// File: rtl/disc_fit_pkg.sv
package disc_fit_pkg;

  typedef enum logic [1:0] {
    WST_HOLD = 2'd0,
    WST_SKIP = 2'd1,
    WST_SUM  = 2'd2
  } win_st_e;

endpackage

// File: rtl/disc_sq_dist.sv
module disc_sq_dist #(
  parameter int DATA_W = 16,
  localparam int SQ_W  = 2 * (DATA_W + 1)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [SQ_W-1:0]   sq_o
);

  logic signed [DATA_W:0] a_x, b_x, diff;
  logic        [DATA_W:0] mag;

  always_comb begin
    a_x  = {a_i[DATA_W-1], a_i};
    b_x  = {b_i[DATA_W-1], b_i};
    diff = a_x - b_x;
    mag  = diff[DATA_W] ? $unsigned(-diff) : $unsigned(diff);
    sq_o = SQ_W'(mag) * SQ_W'(mag);
  end

endmodule

// File: rtl/disc_window_acc.sv
module disc_window_acc
  import disc_fit_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 24,
  parameter int WIN_LEN  = 100,
  parameter int SKIP_LEN = 2,
  localparam int SQ_W    = 2 * (DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [SQ_W-1:0]  sq_i,
  output logic             done_o,
  output logic [ACC_W-1:0] score_o
);

  localparam int SUM_W   = ((ACC_W > SQ_W) ? ACC_W : SQ_W) + 1;
  localparam int WIN_CW  = $clog2(WIN_LEN + 1);
  localparam int SKIP_CW = (SKIP_LEN > 1) ? $clog2(SKIP_LEN + 1) : 1;
  localparam bit HAS_SKIP = (SKIP_LEN > 0);
  localparam logic [SKIP_CW-1:0] SKIP_LAST = HAS_SKIP ? SKIP_CW'(SKIP_LEN - 1) : '0;
  localparam logic [WIN_CW-1:0]  WIN_LAST  = WIN_CW'(WIN_LEN - 1);
  localparam logic [SUM_W-1:0]   ACC_MAX   = (SUM_W'(1) << ACC_W) - SUM_W'(1);

  win_st_e            st_q;
  logic [SKIP_CW-1:0] skip_cnt_q;
  logic [WIN_CW-1:0]  samp_cnt_q;
  logic [ACC_W-1:0]   acc_q, acc_nxt;
  logic [SUM_W-1:0]   sum;
  logic               done_q;

  // saturating add
  always_comb begin
    sum     = SUM_W'(acc_q) + SUM_W'(sq_i);
    acc_nxt = (sum > ACC_MAX) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= WST_HOLD;
      skip_cnt_q <= '0;
      samp_cnt_q <= '0;
      acc_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        st_q       <= HAS_SKIP ? WST_SKIP : WST_SUM;
        skip_cnt_q <= '0;
        samp_cnt_q <= '0;
        acc_q      <= '0;
      end else if (vld_i) begin
        unique case (st_q)
          WST_SKIP: begin
            skip_cnt_q <= skip_cnt_q + 1'b1;
            if (skip_cnt_q == SKIP_LAST) st_q <= WST_SUM;
          end
          WST_SUM: begin
            acc_q      <= acc_nxt;
            samp_cnt_q <= samp_cnt_q + 1'b1;
            if (samp_cnt_q == WIN_LAST) begin
              st_q   <= WST_HOLD;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign score_o = acc_q;

  // R5
  acc_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q));

  // R3
  skip_no_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WST_SKIP) && !clr_i |=> acc_q == $past(acc_q));

  // R4
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_cnt_q <= WIN_CW'(WIN_LEN));

endmodule

// File: rtl/disc_score_tbl.sv
module disc_score_tbl #(
  parameter int ACC_W = 24,
  parameter int DEPTH = 50,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ACC_W-1:0] rd_data_o
);

  localparam logic [IDX_W:0] DEPTH_V = (IDX_W + 1)'(DEPTH);

  logic [ACC_W-1:0] ent_q [DEPTH];
  logic [ACC_W-1:0] rd_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       ent_q[e] <= '1;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e)))       ent_q[e] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_q <= '1;
    else if ({1'b0, rd_idx_i} < DEPTH_V)  rd_q <= ent_q[rd_idx_i];
    else                                  rd_q <= '1;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/disc_fitness_eval.sv
module disc_fitness_eval #(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 24,
  parameter int WIN_LEN  = 100,
  parameter int SKIP_LEN = 2,
  parameter int POP_SIZE = 50,
  localparam int IDX_W   = (POP_SIZE > 1) ? $clog2(POP_SIZE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] lane_a_i,
  input  logic [DATA_W-1:0] lane_b_i,
  output logic [IDX_W-1:0]  cand_idx_o,
  output logic              cfg_load_o,
  output logic              gen_done_o,
  output logic              sol_found_o,
  output logic [IDX_W-1:0]  sol_idx_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ACC_W-1:0]  rd_score_o
);

  localparam int SQ_W = 2 * (DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(POP_SIZE - 1);

  logic [SQ_W-1:0]  sq;
  logic             win_done;
  logic [ACC_W-1:0] win_score;

  logic             started_q, load_q, gen_q, found_q, halt_q;
  logic [IDX_W-1:0] cand_q, sol_idx_q;

  disc_sq_dist #(.DATA_W(DATA_W)) u_sq (
    .a_i  (lane_a_i),
    .b_i  (lane_b_i),
    .sq_o (sq)
  );

  disc_window_acc #(
    .DATA_W  (DATA_W),
    .ACC_W   (ACC_W),
    .WIN_LEN (WIN_LEN),
    .SKIP_LEN(SKIP_LEN)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_q),
    .vld_i  (smp_vld_i),
    .sq_i   (sq),
    .done_o (win_done),
    .score_o(win_score)
  );

  disc_score_tbl #(
    .ACC_W(ACC_W),
    .DEPTH(POP_SIZE),
    .IDX_W(IDX_W)
  ) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (win_done),
    .wr_idx_i (cand_q),
    .wr_data_i(win_score),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_score_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      load_q    <= 1'b0;
      gen_q     <= 1'b0;
      found_q   <= 1'b0;
      halt_q    <= 1'b0;
      cand_q    <= '0;
      sol_idx_q <= '0;
    end else begin
      load_q  <= 1'b0;
      gen_q   <= 1'b0;
      found_q <= 1'b0;
      if (!started_q) begin
        started_q <= 1'b1;
        load_q    <= 1'b1;
      end else if (win_done && !halt_q) begin
        if (cand_q == LAST_IDX) gen_q <= 1'b1;
        if (win_score == '0) begin
          found_q   <= 1'b1;
          sol_idx_q <= cand_q;
          halt_q    <= 1'b1;
        end else begin
          load_q <= 1'b1;
          cand_q <= (cand_q == LAST_IDX) ? '0 : cand_q + 1'b1;
        end
      end
    end
  end

  assign cand_idx_o  = cand_q;
  assign cfg_load_o  = load_q;
  assign gen_done_o  = gen_q;
  assign sol_found_o = found_q;
  assign sol_idx_o   = sol_idx_q;

  // R6
  load_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done |=> (cfg_load_o || sol_found_o));

  // R7
  gen_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_done_o && cfg_load_o) |-> (cand_idx_o == '0));

  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !cfg_load_o);

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_load_o, sol_found_o}));

  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_idx_o <= LAST_IDX);

endmodule

// File: tb/tb_disc_fitness_eval.sv
module tb_disc_fitness_eval;

  localparam int DATA_W = 16;
  localparam int ACC_W  = 24;
  localparam int WIN    = 100;
  localparam int SKIP   = 2;
  localparam int POP    = 50;
  localparam int IDX_W  = 6;
  localparam longint MAXS = (64'd1 << ACC_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              smp_vld_i = 1'b0;
  logic [DATA_W-1:0] lane_a_i = '0, lane_b_i = '0;
  logic [IDX_W-1:0]  cand_idx_o, sol_idx_o, rd_idx_i = '0;
  logic              cfg_load_o, gen_done_o, sol_found_o;
  logic [ACC_W-1:0]  rd_score_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  disc_fitness_eval dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .lane_a_i(lane_a_i), .lane_b_i(lane_b_i),
    .cand_idx_o(cand_idx_o), .cfg_load_o(cfg_load_o), .gen_done_o(gen_done_o),
    .sol_found_o(sol_found_o), .sol_idx_o(sol_idx_o),
    .rd_idx_i(rd_idx_i), .rd_score_o(rd_score_o)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive for one cycle, return at next falling edge
  task automatic cyc(bit v, int a, int b);
    smp_vld_i = v;
    lane_a_i  = DATA_W'(a);
    lane_b_i  = DATA_W'(b);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    smp_vld_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // reset then advance into the first load cycle
  task automatic start();
    do_reset();
    cyc(0, 0, 0);
    chk("R2 first load", cfg_load_o, 1);
    cyc(1, 32767, -32768); // load-cycle sample, R3
  endtask

  // skip + window; returns in cycle k+1
  task automatic run_window(int mode, output longint exp);
    exp = 0;
    for (int s = 0; s < SKIP; s++) cyc(1, -32768, 32767); // R3 skipped
    for (int i = 0; i < WIN; i++) begin
      int a, b;
      longint d;
      if (mode == 1 && (i % 3) == 0) cyc(0, 30000, -30000); // R4 idle
      case (mode)
        0: begin a = i;      b = 0;      end
        1: begin a = -3 * i; b = 2 * i;  end
        2: begin a = i - 50; b = i - 51; end
        3: begin a = 37 * i; b = 37 * i; end
        default: begin
          if (i == 0) begin a = 32767; b = -32768; end
          else begin a = 0; b = 0; end
        end
      endcase
      d = longint'(a) - longint'(b);
      exp = exp + d * d;
      if (exp > MAXS) exp = MAXS;
      cyc(1, a, b);
    end
  endtask

  // from k+1: check timing, then read back score of prev
  task automatic close_window(string req, int prev, int nxt, bit gen, longint exp);
    chk("R6 no load at k+1", cfg_load_o, 0);
    cyc(1, 30000, -30000); // R6 ignored sample
    chk("R6 load at k+2", cfg_load_o, 1);
    chk("R6 next index", cand_idx_o, nxt);
    chk("R7 gen_done", gen_done_o, gen);
    rd_idx_i = IDX_W'(prev);
    cyc(1, -20000, 20000); // load-cycle sample, R3
    chk(req, rd_score_o, exp);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    rd_idx_i = 6'd5;
    repeat (2) @(negedge clk_i);
    chk("R1 cand", cand_idx_o, 0);
    chk("R1 load", cfg_load_o, 0);
    chk("R1 gen", gen_done_o, 0);
    chk("R1 found", sol_found_o, 0);
    chk("R1 sol_idx", sol_idx_o, 0);
    chk("R1 table unscored", rd_score_o, MAXS);
    rst_ni = 1'b1;
    chk("R1 after release", cfg_load_o, 0);
    cyc(0, 0, 0);
    chk("R2 load pulse", cfg_load_o, 1);
    chk("R2 cand 0", cand_idx_o, 0);
    cyc(0, 0, 0);
    chk("R2 single pulse", cfg_load_o, 0);
    chk("R1 table after clock", rd_score_o, MAXS);
  endtask

  task automatic t_basic();
    longint e;
    start();
    run_window(0, e);
    chk("R4 ramp sum", e, 328350);
    close_window("R4 score ramp", 0, 1, 0, e);
    run_window(1, e);
    close_window("R4 score signed with gaps", 1, 2, 0, e);
    chk("R8 no found", sol_found_o, 0);
  endtask

  task automatic t_sat();
    longint e;
    start();
    run_window(4, e);
    close_window("R5 saturated score", 0, 1, 0, MAXS);
  endtask

  task automatic t_gen();
    longint e;
    start();
    for (int c = 0; c < POP; c++) begin
      run_window(2, e);
      close_window("R7 score per cand", c, (c + 1) % POP, (c == POP - 1), 100);
    end
    rd_idx_i = 6'd17;
    cyc(0, 0, 0);
    chk("R9 table kept", rd_score_o, 100);
  endtask

  task automatic t_zero();
    longint e;
    int extra;
    start();
    run_window(2, e);
    close_window("R4 score before zero", 0, 1, 0, 100);
    run_window(3, e);
    chk("R8 no found at k+1", sol_found_o, 0);
    cyc(1, 30000, -30000);
    chk("R8 found pulse", sol_found_o, 1);
    chk("R8 sol_idx", sol_idx_o, 1);
    chk("R8 no load", cfg_load_o, 0);
    chk("R8 cand held", cand_idx_o, 1);
    extra = 0;
    rd_idx_i = 6'd1;
    for (int i = 0; i < WIN + 20; i++) begin
      cyc(1, i * 5, -i);
      if (cfg_load_o || sol_found_o || gen_done_o) extra++;
    end
    chk("R8 halted strobes", extra, 0);
    chk("R9 zero score read", rd_score_o, 0);
    chk("R8 sol_idx kept", sol_idx_o, 1);
    rd_idx_i = 6'd63;
    cyc(0, 0, 0);
    chk("R9 out of range", rd_score_o, MAXS);
    rd_idx_i = 6'd49;
    cyc(0, 0, 0);
    chk("R9 unscored entry", rd_score_o, MAXS);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_sat();
    t_gen();
    t_zero();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule